// File: doc/BRIEF.md
# CAN Transmit Mailbox Arbiter

This block picks which of a bank of message mailboxes puts the next frame on the bus. Each mailbox holds a mode and priority word, an identifier, two 32-bit data words and a control word. Software prepares a mailbox in transmit mode and writes the control word with its go bit set. The mailbox is then pending and its ready flag drops. Whenever no frame is in flight, the arbiter picks the pending transmit mailbox with the smallest priority value. On a tie, the lowest mailbox index wins. It latches that mailbox's frame and presents it to a bit-level transmitter through a request/done/abort handshake.

When the transmitter reports done or abort, the owning mailbox becomes ready again. An abort also sets the mailbox's abort flag. The mailbox's bit in a global completion vector is set and drives the interrupt line if that bit is enabled. A frame in flight is never pre-empted. The next choice is made only after the current frame ends. An identifier may only be rewritten while its mailbox is disabled.

Top module: `can_tx_arbiter`

## Requirements
- R1: After reset every mailbox is disabled with priority 0 and reads ready (status bit 23 = 1) and not aborted (status bit 22 = 0). `tx_req_o`, `irq_flags_o` and `irq_o` are all 0.
- R2: A write with select 4 (control) and data bit 23 set registers a request only if the mailbox mode (mode word bits 26:24) is 3 (transmit) and the mailbox is ready. When accepted, the ready bit reads 0 from the next cycle and the abort bit is cleared. Otherwise the write is ignored.
- R3: Among pending transmit-mode mailboxes, the winner is the one with the smallest 4-bit priority (mode word, select 0, bits 19:16). Equal priorities go to the lowest index.
- R4: The launched frame carries the DLC from control bits 19:16, the remote flag from control bit 20, data word select 2 as `tx_data_o[31:0]` and data word select 3 as `tx_data_o[63:32]`.
- R5: Identifier word (select 1) bit 29 selects an extended frame. An extended frame sends bits 28:0 as `tx_id_o`. A standard frame sends bits 28:18 as `tx_id_o[10:0]`, with the upper bits zero.
- R6: An identifier write is ignored unless the mailbox mode is 0 (disabled).
- R7: While `tx_req_o` is high, `tx_mb_o` and all frame outputs hold until `tx_done_i` or `tx_abort_i` is seen. Requests arriving meanwhile do not displace the frame.
- R8: On done the owning mailbox becomes ready with the abort bit clear. On abort it becomes ready with the abort bit set. Abort takes precedence if both are high.
- R9: Each completion sets `irq_flags_o[mb]`. Bits are cleared by `flag_clr_i`, and a set in the same cycle wins over a clear. `irq_o` is high when any flag whose `irq_en_i` bit is set is high.
- R10: After a completion, `tx_req_o` is low for at least one cycle before the next frame is launched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_mb_i | input | 4 | Mailbox index of the write |
| wr_sel_i | input | 3 | 0 mode/priority, 1 identifier, 2 data low, 3 data high, 4 control |
| wr_data_i | input | 32 | Write data |
| rd_mb_i | input | 4 | Mailbox whose status is shown |
| rd_status_o | output | 32 | Status: bit 23 ready, bit 22 aborted |
| irq_en_i | input | 16 | Per-mailbox interrupt enable |
| flag_clr_i | input | 16 | Per-mailbox completion flag clear |
| irq_flags_o | output | 16 | Completion flags |
| irq_o | output | 1 | Interrupt line |
| tx_req_o | output | 1 | Frame offered to the transmitter |
| tx_mb_o | output | 4 | Mailbox owning the frame |
| tx_ext_o | output | 1 | Extended frame |
| tx_id_o | output | 29 | Identifier |
| tx_rtr_o | output | 1 | Remote request |
| tx_dlc_o | output | 4 | Data length code |
| tx_data_o | output | 64 | Payload |
| tx_done_i | input | 1 | Transmitter finished the frame |
| tx_abort_i | input | 1 | Transmitter abandoned the frame |

## Verification
A wrong pending or ready bit shows one of two ways. Either a mailbox never reaches `tx_mb_o`, or it appears twice, at the launch following the next completion. It also shows as a wrong status read in the cycle after the request or completion. A faulty priority comparison puts the wrong index on `tx_mb_o` in the first launch that needs it. Sweeps with many distinct and tied priority patterns expose it within one drain of the mailbox bank. A stale frame latch or a misrouted completion shows up in the same handshake. It appears either as a changing frame under a held request, or as ready and flag bits landing on the wrong mailbox one cycle after done.

// File: rtl/can_arb_pkg.sv
package can_arb_pkg;
  typedef enum logic [2:0] {
    MB_OFF  = 3'd0,
    MB_RX   = 3'd1,
    MB_RXOV = 3'd2,
    MB_TX   = 3'd3,
    MB_CONS = 3'd4,
    MB_PROD = 3'd5
  } mb_mode_e;

  typedef enum logic [2:0] {
    SEL_MODE = 3'd0,
    SEL_ID   = 3'd1,
    SEL_DLO  = 3'd2,
    SEL_DHI  = 3'd3,
    SEL_CTRL = 3'd4
  } reg_sel_e;

  localparam int MODE_LSB = 24;
  localparam int PRIO_LSB = 16;
  localparam int CTRL_GO  = 23;
  localparam int CTRL_RTR = 20;
  localparam int DLC_LSB  = 16;
  localparam int ID_EXT   = 29;
  localparam int STD_LSB  = 18;
  localparam int ST_READY = 23;
  localparam int ST_ABORT = 22;

  typedef struct packed {
    logic        ext;
    logic [28:0] id;
    logic        rtr;
    logic [3:0]  dlc;
    logic [63:0] data;
  } frame_t;
endpackage

// File: rtl/can_mailbox.sv
module can_mailbox
  import can_arb_pkg::*;
#(
  parameter int PRIO_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [31:0]       wr_data_i,
  input  logic              cpl_i,
  input  logic              cpl_abort_i,
  output logic              cand_o,
  output logic [PRIO_W-1:0] prio_o,
  output frame_t            frame_o,
  output logic              ready_o,
  output logic              abort_o
);
  mb_mode_e          mode_q;
  logic [PRIO_W-1:0] prio_q;
  logic [29:0]       id_q;
  logic [31:0]       dlo_q, dhi_q;
  logic [3:0]        dlc_q;
  logic              rtr_q, pend_q, ready_q, abort_q;
  logic              go_ok;

  assign go_ok = wr_en_i && (wr_sel_i == SEL_CTRL) && wr_data_i[CTRL_GO]
                 && (mode_q == MB_TX) && ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MB_OFF;
      prio_q  <= '0;
      id_q    <= '0;
      dlo_q   <= '0;
      dhi_q   <= '0;
      dlc_q   <= '0;
      rtr_q   <= 1'b0;
      pend_q  <= 1'b0;
      ready_q <= 1'b1;
      abort_q <= 1'b0;
    end else begin
      if (wr_en_i) begin
        case (wr_sel_i)
          SEL_MODE: begin
            mode_q <= mb_mode_e'(wr_data_i[MODE_LSB+:3]);
            prio_q <= wr_data_i[PRIO_LSB+:PRIO_W];
          end
          SEL_ID:  if (mode_q == MB_OFF) id_q <= wr_data_i[29:0];
          SEL_DLO: dlo_q <= wr_data_i;
          SEL_DHI: dhi_q <= wr_data_i;
          default: ;
        endcase
      end
      if (go_ok) begin
        dlc_q   <= wr_data_i[DLC_LSB+:4];
        rtr_q   <= wr_data_i[CTRL_RTR];
        pend_q  <= 1'b1;
        ready_q <= 1'b0;
        abort_q <= 1'b0;
      end else if (cpl_i) begin
        pend_q  <= 1'b0;
        ready_q <= 1'b1;
        abort_q <= cpl_abort_i;
      end
    end
  end

  assign cand_o  = pend_q && (mode_q == MB_TX);
  assign prio_o  = prio_q;
  assign ready_o = ready_q;
  assign abort_o = abort_q;

  always_comb begin
    frame_o.ext  = id_q[ID_EXT];
    frame_o.id   = id_q[ID_EXT] ? id_q[28:0] : {18'd0, id_q[28:STD_LSB]};
    frame_o.rtr  = rtr_q;
    frame_o.dlc  = dlc_q;
    frame_o.data = {dhi_q, dlo_q};
  end

  // R2: accepted request drops ready and marks pending
  a_r2_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_CTRL && wr_data_i[CTRL_GO] && mode_q == MB_TX && ready_q)
    |=> (!ready_q && pend_q && !abort_q));
  // R6: identifier frozen unless disabled
  a_r6_id_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_ID && mode_q != MB_OFF) |=> $stable(id_q));
  // R8: completion restores ready, abort flag follows the cause
  a_r8_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_i && !go_ok) |=> (ready_q && !pend_q && abort_q == $past(cpl_abort_i)));
endmodule

// File: rtl/can_prio_pick.sv
module can_prio_pick #(
  parameter int N      = 16,
  parameter int PRIO_W = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N-1:0]             cand_i,
  input  logic [N-1:0][PRIO_W-1:0] prio_i,
  output logic                     any_o,
  output logic [IDX_W-1:0]         idx_o
);
  logic [PRIO_W-1:0] best;
  logic              beaten;

  // strict less-than keeps the lowest index on ties
  always_comb begin
    any_o = 1'b0;
    best  = '1;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (!any_o || prio_i[i] < best)) begin
        any_o = 1'b1;
        best  = prio_i[i];
        idx_o = IDX_W'(i);
      end
    end
  end

  // independent check: nobody should outrank the chosen one
  always_comb begin
    beaten = 1'b0;
    for (int j = 0; j < N; j++) begin
      if (cand_i[j] && (prio_i[j] < prio_i[idx_o] ||
          (prio_i[j] == prio_i[idx_o] && IDX_W'(j) < idx_o)))
        beaten = 1'b1;
    end
  end

  a_r3_best: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> !beaten);
  a_r3_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> cand_i[idx_o]);
  a_r3_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_i == '0) |-> !any_o);
endmodule

// File: rtl/can_tx_seq.sv
module can_tx_seq
  import can_arb_pkg::*;
#(
  parameter int NUM_MB = 16,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             any_i,
  input  logic [IDX_W-1:0] win_idx_i,
  input  frame_t           win_frame_i,
  input  logic             tx_done_i,
  input  logic             tx_abort_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] cur_idx_o,
  output frame_t           frame_o,
  output logic             cpl_o,
  output logic             cpl_abort_o
);
  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  frame_t           frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      frame_q <= '0;
    end else if (!busy_q) begin
      if (any_i) begin
        busy_q  <= 1'b1;
        idx_q   <= win_idx_i;
        frame_q <= win_frame_i;
      end
    end else if (tx_done_i || tx_abort_i) begin
      busy_q <= 1'b0;
    end
  end

  assign busy_o      = busy_q;
  assign cur_idx_o   = idx_q;
  assign frame_o     = frame_q;
  assign cpl_o       = busy_q && (tx_done_i || tx_abort_i);
  assign cpl_abort_o = busy_q && tx_abort_i;

  // R7: no pre-emption while in flight
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tx_done_i && !tx_abort_i) |=> (busy_q && $stable(idx_q) && $stable(frame_q)));
  // R10: gap between frames
  a_r10_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && (tx_done_i || tx_abort_i)) |=> !busy_q);
endmodule

// File: rtl/can_tx_arbiter.sv
module can_tx_arbiter
  import can_arb_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int PRIO_W = 4,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_mb_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [31:0]       wr_data_i,
  input  logic [IDX_W-1:0]  rd_mb_i,
  output logic [31:0]       rd_status_o,
  input  logic [NUM_MB-1:0] irq_en_i,
  input  logic [NUM_MB-1:0] flag_clr_i,
  output logic [NUM_MB-1:0] irq_flags_o,
  output logic              irq_o,
  output logic              tx_req_o,
  output logic [IDX_W-1:0]  tx_mb_o,
  output logic              tx_ext_o,
  output logic [28:0]       tx_id_o,
  output logic              tx_rtr_o,
  output logic [3:0]        tx_dlc_o,
  output logic [63:0]       tx_data_o,
  input  logic              tx_done_i,
  input  logic              tx_abort_i
);
  logic [NUM_MB-1:0]             cand_v, ready_v, abort_v, cpl_v;
  logic [NUM_MB-1:0][PRIO_W-1:0] prio_v;
  frame_t                        frame_v [NUM_MB];
  logic                          any_w, cpl_w, cpl_abort_w;
  logic [IDX_W-1:0]              win_idx, cur_idx;
  frame_t                        cur_frame;
  logic [NUM_MB-1:0]             flags_q;

  for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
    assign cpl_v[g] = cpl_w && (cur_idx == IDX_W'(g));
    can_mailbox #(.PRIO_W(PRIO_W)) u_mb (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_en_i     (wr_en_i && (wr_mb_i == IDX_W'(g))),
      .wr_sel_i    (wr_sel_i),
      .wr_data_i   (wr_data_i),
      .cpl_i       (cpl_v[g]),
      .cpl_abort_i (cpl_abort_w),
      .cand_o      (cand_v[g]),
      .prio_o      (prio_v[g]),
      .frame_o     (frame_v[g]),
      .ready_o     (ready_v[g]),
      .abort_o     (abort_v[g])
    );
  end

  can_prio_pick #(.N(NUM_MB), .PRIO_W(PRIO_W)) u_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cand_i (cand_v),
    .prio_i (prio_v),
    .any_o  (any_w),
    .idx_o  (win_idx)
  );

  can_tx_seq #(.NUM_MB(NUM_MB)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .any_i       (any_w),
    .win_idx_i   (win_idx),
    .win_frame_i (frame_v[win_idx]),
    .tx_done_i   (tx_done_i),
    .tx_abort_i  (tx_abort_i),
    .busy_o      (tx_req_o),
    .cur_idx_o   (cur_idx),
    .frame_o     (cur_frame),
    .cpl_o       (cpl_w),
    .cpl_abort_o (cpl_abort_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~flag_clr_i) | cpl_v;
  end

  always_comb begin
    rd_status_o           = '0;
    rd_status_o[ST_READY] = ready_v[rd_mb_i];
    rd_status_o[ST_ABORT] = abort_v[rd_mb_i];
  end

  assign irq_flags_o = flags_q;
  assign irq_o       = |(flags_q & irq_en_i);
  assign tx_mb_o     = cur_idx;
  assign tx_ext_o    = cur_frame.ext;
  assign tx_id_o     = cur_frame.id;
  assign tx_rtr_o    = cur_frame.rtr;
  assign tx_dlc_o    = cur_frame.dlc;
  assign tx_data_o   = cur_frame.data;

  // R9: completion lands on the owner's flag
  a_r9_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_o && (tx_done_i || tx_abort_i)) |=> irq_flags_o[$past(tx_mb_o)]);
  // R8: owner reads ready right after completion
  a_r8_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_o && (tx_done_i || tx_abort_i)) |=> ready_v[$past(tx_mb_o)]);
endmodule

// File: tb/sim_can_tx_arbiter.sv
`timescale 1ns/1ps
module sim_can_tx_arbiter;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_mb_i = '0;
  logic [2:0]  wr_sel_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [3:0]  rd_mb_i = '0;
  logic [31:0] rd_status_o;
  logic [15:0] irq_en_i = '0;
  logic [15:0] flag_clr_i = '0;
  logic [15:0] irq_flags_o;
  logic        irq_o, tx_req_o, tx_ext_o, tx_rtr_o;
  logic [3:0]  tx_mb_o, tx_dlc_o;
  logic [28:0] tx_id_o;
  logic [63:0] tx_data_o;
  logic        tx_done_i = 1'b0;
  logic        tx_abort_i = 1'b0;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  int          m_prio [16];
  bit          m_pend [16];
  bit          m_ext  [16];
  logic [28:0] m_id   [16];
  bit          m_rtr  [16];
  logic [3:0]  m_dlc  [16];
  logic [63:0] m_data [16];

  always #2.5 clk = ~clk;

  can_tx_arbiter u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_mb_i(wr_mb_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_mb_i(rd_mb_i),
    .rd_status_o(rd_status_o), .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i),
    .irq_flags_o(irq_flags_o), .irq_o(irq_o), .tx_req_o(tx_req_o),
    .tx_mb_o(tx_mb_o), .tx_ext_o(tx_ext_o), .tx_id_o(tx_id_o),
    .tx_rtr_o(tx_rtr_o), .tx_dlc_o(tx_dlc_o), .tx_data_o(tx_data_o),
    .tx_done_i(tx_done_i), .tx_abort_i(tx_abort_i)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int mb, int sel, logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_mb_i = 4'(mb); wr_sel_i = 3'(sel); wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_st(int mb, output logic rdy, output logic ab);
    rd_mb_i = 4'(mb);
    #0.5;
    rdy = rd_status_o[23];
    ab  = rd_status_o[22];
  endtask

  task automatic cfg(int i, int prio, bit ext, logic [28:0] id, bit rtr,
                     logic [3:0] dlc, logic [63:0] data);
    wr(i, 0, 32'd0);
    wr(i, 1, ext ? {2'b00, 1'b1, id} : {3'b000, id[10:0], 18'd0});
    wr(i, 0, (32'd3 << 24) | (32'(prio) << 16));
    wr(i, 2, data[31:0]);
    wr(i, 3, data[63:32]);
    m_prio[i] = prio; m_ext[i] = ext; m_id[i] = ext ? id : {18'd0, id[10:0]};
    m_rtr[i] = rtr; m_dlc[i] = dlc; m_data[i] = data;
  endtask

  task automatic req(int i);
    wr(i, 4, (32'd1 << 23) | (32'(m_rtr[i]) << 20) | (32'(m_dlc[i]) << 16));
    m_pend[i] = 1;
  endtask

  function automatic int model_pick();
    int best = -1;
    for (int i = 0; i < 16; i++)
      if (m_pend[i] && (best < 0 || m_prio[i] < m_prio[best])) best = i;
    return best;
  endfunction

  task automatic serve(int exp, bit ab);
    logic rdy, abt;
    for (int k = 0; k < 40; k++) begin
      if (tx_req_o) break;
      @(negedge clk);
    end
    chk("R3 winner", 64'(tx_mb_o), 64'(exp));
    chk("R4 dlc", 64'(tx_dlc_o), 64'(m_dlc[exp]));
    chk("R4 rtr", 64'(tx_rtr_o), 64'(m_rtr[exp]));
    chk("R4 data", tx_data_o, m_data[exp]);
    chk("R5 ext", 64'(tx_ext_o), 64'(m_ext[exp]));
    chk("R5 id", 64'(tx_id_o), 64'(m_id[exp]));
    rd_st(exp, rdy, abt);
    chk("R2 ready low while pending", 64'(rdy), 64'd0);
    chk("R2 abort cleared on request", 64'(abt), 64'd0);
    @(negedge clk);
    chk("R7 held mb", 64'(tx_mb_o), 64'(exp));
    chk("R7 held req", 64'(tx_req_o), 64'd1);
    tx_done_i = !ab; tx_abort_i = ab;
    @(negedge clk);
    tx_done_i = 1'b0; tx_abort_i = 1'b0;
    chk("R10 req gap", 64'(tx_req_o), 64'd0);
    rd_st(exp, rdy, abt);
    chk("R8 ready after end", 64'(rdy), 64'd1);
    chk("R8 abort flag", 64'(abt), 64'(ab));
    chk("R9 flag set", 64'(irq_flags_o), 64'(16'd1 << exp));
    chk("R9 irq", 64'(irq_o), 64'(irq_en_i[exp]));
    m_pend[exp] = 0;
    flag_clr_i = 16'd1 << exp;
    @(negedge clk);
    flag_clr_i = '0;
    chk("R9 flag cleared", 64'(irq_flags_o), 64'd0);
    chk("R9 irq cleared", 64'(irq_o), 64'd0);
  endtask

  initial begin
    logic rdy, abt;
    for (int i = 0; i < 16; i++) m_pend[i] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tx_req", 64'(tx_req_o), 64'd0);
    chk("R1 flags", 64'(irq_flags_o), 64'd0);
    chk("R1 irq", 64'(irq_o), 64'd0);
    for (int i = 0; i < 16; i++) begin
      rd_st(i, rdy, abt);
      chk("R1 ready", 64'(rdy), 64'd1);
      chk("R1 abort", 64'(abt), 64'd0);
    end

    // sweeps over priority patterns, distinct and tied
    for (int r = 0; r < 6; r++) begin
      irq_en_i = (r % 2 == 1) ? 16'hFFFF : 16'h5555;
      for (int i = 0; i < 16; i++) begin
        int p;
        p = (r % 2 == 0) ? ((i * 5 + r * 3) % 16) : ((i + r) % 3);
        cfg(i, p, i[0], 29'((r * 16 + i) * 12345 + r), bit'((i + r) % 3 == 0),
            4'((i + r) % 9), {32'(r * 977 + i), 32'(i * 31337 + r)});
      end
      // mb15 is alone when the first launch happens (R7 no displacement)
      for (int i = 15; i >= 0; i--) req(i);
      serve(15, ((r + 15) % 5) == 0);
      for (int k = 0; k < 15; k++) begin
        int w;
        w = model_pick();
        serve(w, ((r + w) % 5) == 0);
      end
    end

    // R6: identifier write while in transmit mode is ignored
    cfg(3, 2, 1'b0, 29'h5A5, 1'b0, 4'd2, 64'h1122334455667788);
    wr(3, 1, 32'h2ABCDEF0);
    req(3);
    serve(3, 1'b0);

    // R6: identifier write while disabled takes effect
    cfg(6, 1, 1'b1, 29'h1BCDE012, 1'b1, 4'd8, 64'hCAFE0000BEEF0001);
    req(6);
    serve(6, 1'b0);

    // R2: request on a receive-mode mailbox is ignored
    wr(4, 0, 32'd1 << 24);
    wr(4, 4, 32'd1 << 23);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R2 no launch from rx mode", 64'(tx_req_o), 64'd0);
    end
    rd_st(4, rdy, abt);
    chk("R2 rx mode stays ready", 64'(rdy), 64'd1);

    // R2: control write without go bit is ignored
    cfg(5, 0, 1'b0, 29'h7, 1'b0, 4'd1, 64'd5);
    wr(5, 4, 32'h000F0000);
    repeat (4) @(negedge clk);
    chk("R2 no go bit", 64'(tx_req_o), 64'd0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule